// File: doc/BRIEF.md
# Tiny Two-Register Processor Core

A small processor core that runs one-byte instructions out of a 256-byte program store and completes each instruction in one clock. It holds two 8-bit working registers (called A0 and A1 below, R0/R1 in the opcode notes), a carry flag and a 16-byte scratch RAM. The opcode space packs register selects, nibble immediates, RAM addresses, shift amounts and jump offsets into 2 to 4 bit fields. Jumps can be relative, within 3 steps back or 7 steps forward, or absolute through a register. Either kind can depend on carry.

The program store sits outside the core. The core drives the fetch address and reads the byte combinationally in the same cycle. A byte port links the core to its surroundings. It has a ready input that software can copy into carry, an input byte that a read instruction loads into A0, and an output byte that always shows A0. Read and write strobes last one cycle. A halt instruction stops the core until reset.

Two-operand operations use A0 and A1 as inputs and write the result back to A0. MUL writes a 16-bit product with the high byte in A1 and the low byte in A0. DIV writes the quotient to A0 and the remainder to A1.

Top module: `tcpu_core`

## Requirements
- R1: Reset (rst_ni low, asynchronous) sets the fetch address to 0x00. It clears both registers, carry, every RAM byte and the halted state.
- R2: 000r_aaaa loads RAM byte aaaa into the register selected by bit 4 (0 = A0, 1 = A1). 001r_aaaa writes that register to RAM byte aaaa.
- R3: 01hr_vvvv replaces one nibble of the register selected by bit 4 with vvvv: the high nibble when bit 5 = 1, the low nibble when bit 5 = 0. The other nibble is kept.
- R4: Relative jumps count from the jump's own address. 1000_1coo moves back by oo and 1001_cooo moves forward by ooo. With c = 1 the jump happens only when carry is 1; otherwise execution falls through to the next address. 0x90 repeats itself forever.
- R5: 1000_00rc jumps to the address held in the selected register (bit 1). With c = 1 it jumps only when carry is 1.
- R6: 0x84, 0x85 and 0x86 set carry to A0==A1, A0>A1 and A0<A1 (unsigned). 0x87 inverts carry.
- R7: 101r_mlll and 110r_mlll shift the selected register right or left by lll bits. m = 0 is a logical shift and m = 1 a rotate. 0xEC–0xEF shift A0 by A1[2:0]; bit 1 = 1 means left and bit 0 = 1 means rotate. Shifts leave carry unchanged.
- R8: 0xE4–0xE9 compute A0 op A1 into A0, for ADD, SUB, AND, OR, XOR and XNOR in that order. ADD sets carry to the carry-out. SUB sets carry to the borrow. 0xE0/E1 increment A0/A1, 0xE2/E3 decrement them, and 0xEA/EB invert them bitwise.
- R9: 0xF0 copies A0 into A1 and 0xF1 copies A1 into A0. 0xF2/F3 set carry to 0/1. 0xF6/F7 load 0x00 or 0x01 (the carry) into A0/A1. 0xF8/F9 clear A0/A1. 0xF4 does nothing.
- R10: 0xFB puts the product A0*A1 into {A1,A0}. 0xFC swaps A0 and A1. 0xFA puts A0/A1 into A0 and A0%A1 into A1 and clears carry. If A1 is 0, 0xFA instead sets A0 = 0xFF, A1 = old A0 and carry = 1.
- R11: 0xFD copies port_rdy_i into carry. 0xFE loads port_din_i into A0 and raises port_rd_o for that one cycle. 0xFF raises port_wr_o for one cycle while port_dout_o shows A0.
- R12: 0xF5 raises halted_o from the next cycle until reset. While halted, the fetch address holds and neither strobe rises.
- R13: Every instruction that is not a jump or HALT advances the fetch address by one, and 0xFF wraps to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rom_addr_o | output | 8 | Program fetch address |
| rom_data_i | input | 8 | Instruction byte at rom_addr_o, same cycle |
| port_rdy_i | input | 1 | Port ready status |
| port_din_i | input | 8 | Port input byte |
| port_rd_o | output | 1 | One-cycle read strobe |
| port_dout_o | output | 8 | Port output byte (A0) |
| port_wr_o | output | 1 | One-cycle write strobe |
| halted_o | output | 1 | Core stopped by HALT |

## Verification
The properties assume rom_data_i is the byte stored at rom_addr_o during that same cycle. They also assume it changes only when the address changes or while reset is low. The bench models the program store as an array read combinationally at the fetch address. It rewrites the array only while reset is held low, and it keeps port_rdy_i and port_din_i constant, so every sampled instruction is the one the core executed.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned PAW = 8;
  localparam int unsigned DAW = 4;
  localparam int unsigned DDEPTH = 1 << DAW;
  localparam int unsigned SAW = $clog2(DW);

  typedef enum logic [5:0] {
    OP_NOP, OP_LD, OP_ST, OP_LDI, OP_JREL, OP_JABS, OP_EQ, OP_GT, OP_LT, OP_NOTC,
    OP_SHI, OP_SHV, OP_INC, OP_DEC, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_XNOR,
    OP_CPL, OP_MOV, OP_SETC, OP_HALT, OP_CLD, OP_CLR, OP_DIV, OP_MUL, OP_SWAP,
    OP_PCHK, OP_PRD, OP_PWR
  } op_e;

  typedef struct packed {
    op_e            op;
    logic           sel;   // 0: A0, 1: A1
    logic           cond;  // needs carry
    logic           back;
    logic [2:0]     off;
    logic           hi;
    logic [3:0]     imm;
    logic [DAW-1:0] addr;
    logic           left;
    logic           rot;
    logic [SAW-1:0] amt;
    logic           cval;
  } ctl_t;
endpackage

// File: rtl/tcpu_decode.sv
module tcpu_decode
  import tcpu_pkg::*;
(
  input  logic [7:0] instr_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o      = '0;
    ctl_o.op   = OP_NOP;
    ctl_o.sel  = instr_i[4];
    ctl_o.addr = instr_i[DAW-1:0];
    ctl_o.imm  = instr_i[3:0];
    ctl_o.hi   = instr_i[5];
    ctl_o.rot  = instr_i[3];
    ctl_o.amt  = instr_i[SAW-1:0];
    unique casez (instr_i)
      8'b000?_????: ctl_o.op = OP_LD;
      8'b001?_????: ctl_o.op = OP_ST;
      8'b01??_????: ctl_o.op = OP_LDI;
      8'b1000_00??: begin
        ctl_o.op   = OP_JABS;
        ctl_o.sel  = instr_i[1];
        ctl_o.cond = instr_i[0];
      end
      8'b1000_01??: begin
        unique case (instr_i[1:0])
          2'd0: ctl_o.op = OP_EQ;
          2'd1: ctl_o.op = OP_GT;
          2'd2: ctl_o.op = OP_LT;
          default: ctl_o.op = OP_NOTC;
        endcase
      end
      8'b1000_1???: begin
        ctl_o.op   = OP_JREL;
        ctl_o.back = 1'b1;
        ctl_o.cond = instr_i[2];
        ctl_o.off  = {1'b0, instr_i[1:0]};
      end
      8'b1001_????: begin
        ctl_o.op   = OP_JREL;
        ctl_o.cond = instr_i[3];
        ctl_o.off  = instr_i[2:0];
      end
      8'b101?_????: ctl_o.op = OP_SHI;
      8'b110?_????: begin
        ctl_o.op   = OP_SHI;
        ctl_o.left = 1'b1;
      end
      8'b1110_00??: begin
        ctl_o.op  = instr_i[1] ? OP_DEC : OP_INC;
        ctl_o.sel = instr_i[0];
      end
      8'b1110_01??: begin
        unique case (instr_i[1:0])
          2'd0: ctl_o.op = OP_ADD;
          2'd1: ctl_o.op = OP_SUB;
          2'd2: ctl_o.op = OP_AND;
          default: ctl_o.op = OP_OR;
        endcase
      end
      8'b1110_100?: ctl_o.op = instr_i[0] ? OP_XNOR : OP_XOR;
      8'b1110_101?: begin
        ctl_o.op  = OP_CPL;
        ctl_o.sel = instr_i[0];
      end
      8'b1110_11??: begin
        ctl_o.op   = OP_SHV;
        ctl_o.sel  = 1'b0;
        ctl_o.left = instr_i[1];
        ctl_o.rot  = instr_i[0];
      end
      8'b1111_000?: begin
        ctl_o.op  = OP_MOV;
        ctl_o.sel = instr_i[0];
      end
      8'b1111_001?: begin
        ctl_o.op   = OP_SETC;
        ctl_o.cval = instr_i[0];
      end
      8'b1111_0100: ctl_o.op = OP_NOP;
      8'b1111_0101: ctl_o.op = OP_HALT;
      8'b1111_011?: begin
        ctl_o.op  = OP_CLD;
        ctl_o.sel = instr_i[0];
      end
      8'b1111_100?: begin
        ctl_o.op  = OP_CLR;
        ctl_o.sel = instr_i[0];
      end
      8'b1111_1010: ctl_o.op = OP_DIV;
      8'b1111_1011: ctl_o.op = OP_MUL;
      8'b1111_1100: ctl_o.op = OP_SWAP;
      8'b1111_1101: ctl_o.op = OP_PCHK;
      8'b1111_1110: ctl_o.op = OP_PRD;
      default:      ctl_o.op = OP_PWR;
    endcase
  end
endmodule

// File: rtl/tcpu_shift.sv
module tcpu_shift #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  input  logic          rot_i,
  output logic [W-1:0]  res_o
);
  logic [2*W-1:0] dbl_l, dbl_r;

  always_comb begin
    dbl_l = {val_i, val_i} << amt_i;
    dbl_r = {val_i, val_i} >> amt_i;
    unique case ({left_i, rot_i})
      2'b00: res_o = val_i >> amt_i;
      2'b01: res_o = dbl_r[W-1:0];
      2'b10: res_o = val_i << amt_i;
      default: res_o = dbl_l[2*W-1:W];
    endcase
  end
endmodule

// File: rtl/tcpu_exec.sv
module tcpu_exec
  import tcpu_pkg::*;
(
  input  ctl_t          ctl_i,
  input  logic [PAW-1:0] pc_i,
  input  logic [DW-1:0] r0_i,
  input  logic [DW-1:0] r1_i,
  input  logic          c_i,
  input  logic [DW-1:0] mem_i,
  input  logic [DW-1:0] pdin_i,
  input  logic          prdy_i,
  output logic [DW-1:0] r0_o,
  output logic [DW-1:0] r1_o,
  output logic          c_o,
  output logic [PAW-1:0] pc_o
);
  logic [DW-1:0]   src, res, sh_in, sh_res;
  logic [SAW-1:0]  sh_amt;
  logic            wr_sel, take;
  logic [DW:0]     wide;
  logic [2*DW-1:0] prod;

  assign src    = ctl_i.sel ? r1_i : r0_i;
  assign sh_in  = (ctl_i.op == OP_SHV) ? r0_i : src;
  assign sh_amt = (ctl_i.op == OP_SHV) ? r1_i[SAW-1:0] : ctl_i.amt;
  assign prod   = {{DW{1'b0}}, r0_i} * {{DW{1'b0}}, r1_i};
  assign take   = ~ctl_i.cond | c_i;

  tcpu_shift #(.W(DW)) u_shift (
    .val_i (sh_in),
    .amt_i (sh_amt),
    .left_i(ctl_i.left),
    .rot_i (ctl_i.rot),
    .res_o (sh_res)
  );

  always_comb begin
    r0_o   = r0_i;
    r1_o   = r1_i;
    c_o    = c_i;
    res    = '0;
    wr_sel = 1'b0;
    wide   = '0;
    unique case (ctl_i.op)
      OP_LD:   begin res = mem_i; wr_sel = 1'b1; end
      OP_LDI:  begin
        res    = ctl_i.hi ? {ctl_i.imm, src[3:0]} : {src[DW-1:4], ctl_i.imm};
        wr_sel = 1'b1;
      end
      OP_EQ:   c_o = (r0_i == r1_i);
      OP_GT:   c_o = (r0_i > r1_i);
      OP_LT:   c_o = (r0_i < r1_i);
      OP_NOTC: c_o = ~c_i;
      OP_SHI:  begin res = sh_res; wr_sel = 1'b1; end
      OP_SHV:  r0_o = sh_res;
      OP_INC:  begin res = src + 1'b1; wr_sel = 1'b1; end
      OP_DEC:  begin res = src - 1'b1; wr_sel = 1'b1; end
      OP_CPL:  begin res = ~src; wr_sel = 1'b1; end
      OP_ADD:  begin
        wide = {1'b0, r0_i} + {1'b0, r1_i};
        r0_o = wide[DW-1:0];
        c_o  = wide[DW];
      end
      OP_SUB:  begin
        wide = {1'b0, r0_i} - {1'b0, r1_i};
        r0_o = wide[DW-1:0];
        c_o  = wide[DW];
      end
      OP_AND:  r0_o = r0_i & r1_i;
      OP_OR:   r0_o = r0_i | r1_i;
      OP_XOR:  r0_o = r0_i ^ r1_i;
      OP_XNOR: r0_o = ~(r0_i ^ r1_i);
      OP_MOV:  if (ctl_i.sel) r0_o = r1_i; else r1_o = r0_i;
      OP_SETC: c_o = ctl_i.cval;
      OP_CLD:  begin res = {{(DW-1){1'b0}}, c_i}; wr_sel = 1'b1; end
      OP_CLR:  begin res = '0; wr_sel = 1'b1; end
      OP_DIV:  begin
        if (r1_i == '0) begin
          r0_o = '1;
          r1_o = r0_i;
          c_o  = 1'b1;
        end else begin
          r0_o = r0_i / r1_i;
          r1_o = r0_i % r1_i;
          c_o  = 1'b0;
        end
      end
      OP_MUL:  {r1_o, r0_o} = prod;
      OP_SWAP: begin r0_o = r1_i; r1_o = r0_i; end
      OP_PCHK: c_o = prdy_i;
      OP_PRD:  r0_o = pdin_i;
      default: ;
    endcase
    if (wr_sel) begin
      if (ctl_i.sel) r1_o = res;
      else           r0_o = res;
    end
  end

  always_comb begin
    unique case (ctl_i.op)
      OP_JREL: pc_o = !take ? pc_i + 1'b1 :
                      ctl_i.back ? pc_i - PAW'(ctl_i.off) : pc_i + PAW'(ctl_i.off);
      OP_JABS: pc_o = take ? src : pc_i + 1'b1;
      OP_HALT: pc_o = pc_i;
      default: pc_o = pc_i + 1'b1;
    endcase
  end
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PAW-1:0] rom_addr_o,
  input  logic [DW-1:0] rom_data_i,
  input  logic          port_rdy_i,
  input  logic [DW-1:0] port_din_i,
  output logic          port_rd_o,
  output logic [DW-1:0] port_dout_o,
  output logic          port_wr_o,
  output logic          halted_o
);
  ctl_t           ctl;
  logic [PAW-1:0] pc_q, pc_d;
  logic [DW-1:0]  r0_q, r1_q, r0_d, r1_d;
  logic           c_q, c_d, halt_q, run;
  logic [DW-1:0]  mem_q [DDEPTH];
  logic           st_en;

  assign run = ~halt_q;

  tcpu_decode u_dec (
    .instr_i(rom_data_i),
    .ctl_o  (ctl)
  );

  tcpu_exec u_exec (
    .ctl_i (ctl),
    .pc_i  (pc_q),
    .r0_i  (r0_q),
    .r1_i  (r1_q),
    .c_i   (c_q),
    .mem_i (mem_q[ctl.addr]),
    .pdin_i(port_din_i),
    .prdy_i(port_rdy_i),
    .r0_o  (r0_d),
    .r1_o  (r1_d),
    .c_o   (c_d),
    .pc_o  (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      r0_q   <= '0;
      r1_q   <= '0;
      c_q    <= 1'b0;
      halt_q <= 1'b0;
    end else if (run) begin
      pc_q   <= pc_d;
      r0_q   <= r0_d;
      r1_q   <= r1_d;
      c_q    <= c_d;
      halt_q <= (ctl.op == OP_HALT);
    end
  end

  assign st_en = run && (ctl.op == OP_ST);

  for (genvar gi = 0; gi < DDEPTH; gi++) begin : g_ram
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[gi] <= '0;
      else if (st_en && ctl.addr == DAW'(gi))
        mem_q[gi] <= ctl.sel ? r1_q : r0_q;
    end
  end

  assign rom_addr_o  = pc_q;
  assign halted_o    = halt_q;
  assign port_dout_o = r0_q;
  assign port_rd_o   = run && (ctl.op == OP_PRD);
  assign port_wr_o   = run && (ctl.op == OP_PWR);
endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rom_addr_o,
  input logic [7:0] rom_data_i,
  input logic       port_rd_o,
  input logic       port_wr_o,
  input logic       halted_o
);
  logic is_flow;
  assign is_flow = (rom_data_i[7:2] == 6'b1000_00) || (rom_data_i[7:3] == 5'b1000_1) ||
                   (rom_data_i[7:4] == 4'b1001) || (rom_data_i == 8'hF5);

  // R12
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(rom_addr_o));

  // R12
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !port_rd_o && !port_wr_o);

  // R12
  halt_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && rom_data_i == 8'hF5) |=> halted_o && $stable(rom_addr_o));

  // R13
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !is_flow) |=> rom_addr_o == $past(rom_addr_o) + 8'd1);

  // R4
  self_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && rom_data_i == 8'h90) |=> $stable(rom_addr_o));

  // R11
  wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_o |-> rom_data_i == 8'hFF && !port_rd_o);
endmodule

bind tcpu_core tcpu_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rom_addr_o(rom_addr_o),
  .rom_data_i(rom_data_i),
  .port_rd_o (port_rd_o),
  .port_wr_o (port_wr_o),
  .halted_o  (halted_o)
);

// File: tb/tcpu_core_tb.sv
`timescale 1ns/1ps
module tcpu_core_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] rom_addr_o, rom_data_i, port_dout_o;
  logic       port_rd_o, port_wr_o, halted_o;
  logic       port_rdy_i = 1'b1;
  logic [7:0] port_din_i = 8'h3C;
  logic [7:0] rom [256];
  int         errors = 0;
  int         checks = 0;

  always #10 clk_i = ~clk_i;
  assign rom_data_i = rom[rom_addr_o];

  tcpu_core u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rom_addr_o (rom_addr_o),
    .rom_data_i (rom_data_i),
    .port_rdy_i (port_rdy_i),
    .port_din_i (port_din_i),
    .port_rd_o  (port_rd_o),
    .port_dout_o(port_dout_o),
    .port_wr_o  (port_wr_o),
    .halted_o   (halted_o)
  );

  typedef struct packed {
    logic [63:0] prog;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{64'h6A454CFFF5F5F5F5, 8'hAC, 8'd3},  // R3
    '{64'h476325F815F1FFF5, 8'h37, 8'd2},  // R2
    '{64'h1FF1FFF5F5F5F5F5, 8'h00, 8'd1},  // R1 RAM cleared
    '{64'hF6FFF5F5F5F5F5F5, 8'h00, 8'd1},  // R1 carry cleared
    '{64'h6F72E4FFF5F5F5F5, 8'h10, 8'd8},  // R8
    '{64'h6F72E4F6FFF5F5F5, 8'h01, 8'd8},
    '{64'h4557E5FFF5F5F5F5, 8'hFE, 8'd8},
    '{64'h4557E5F6FFF5F5F5, 8'h01, 8'd8},
    '{64'h6C457956E8FFF5F5, 8'h53, 8'd8},
    '{64'h6C457956E9FFF5F5, 8'hAC, 8'd8},
    '{64'h6F4FE0E2E2EAFFF5, 8'h01, 8'd8},
    '{64'h6841A9CBFFF5F5F5, 8'h06, 8'd7},  // R7
    '{64'h6B4453ECEFFFF5F5, 8'hB0, 8'd7},
    '{64'h45558487F6FFF5F5, 8'h00, 8'd6},  // R6
    '{64'h495585F6FFF5F5F5, 8'h01, 8'd6},
    '{64'h495586F6FFF5F5F5, 8'h00, 8'd6},
    '{64'hF39A4EFFF5F5F5F5, 8'h00, 8'd4},  // R4
    '{64'hF29A4EFFF5F5F5F5, 8'h0E, 8'd4},
    '{64'h44E1858EF1FFF5F5, 8'h04, 8'd4},
    '{64'h46804AF5F5F5FFF5, 8'h06, 8'd5},  // R5
    '{64'h46814AFFF5F5F5F5, 8'h0A, 8'd5},
    '{64'h6AF0F8F1FFF5F5F5, 8'hA0, 8'd9},  // R9
    '{64'hF3F7F1FFF5F5F5F5, 8'h01, 8'd9},
    '{64'h614C7152FBFCFFF5, 8'h01, 8'd10}, // R10
    '{64'h614C7152FBFFF5F5, 8'hF8, 8'd10},
    '{64'h664457FAFCFFF5F5, 8'h02, 8'd10},
    '{64'h664457FAFFF5F5F5, 8'h0E, 8'd10},
    '{64'h6644FAFFF5F5F5F5, 8'hFF, 8'd10},
    '{64'hFEFFF5F5F5F5F5F5, 8'h3C, 8'd11}, // R11
    '{64'hFDF6FFF5F5F5F5F5, 8'h01, 8'd11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] b);
    for (int i = 0; i < 256; i++) rom[i] = b;
  endtask

  task automatic restart();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got, hold;
    int wr_cnt, rd_cnt;
    fill(8'hF4);
    @(negedge clk_i);
    // R1 reset state
    chk("R1 addr", rom_addr_o, 0);
    chk("R1 halted", halted_o, 0);
    chk("R1 dout", port_dout_o, 0);

    for (int v = 0; v < NV; v++) begin
      rst_ni = 1'b0;
      fill(8'hF5);
      for (int b = 0; b < 8; b++) rom[b] = VECS[v].prog[63-8*b -: 8];
      restart();
      got = 8'hXX; wr_cnt = 0; rd_cnt = 0;
      for (int k = 0; k < 80; k++) begin
        if (halted_o) break;
        if (port_wr_o) begin wr_cnt++; got = port_dout_o; end
        if (port_rd_o) rd_cnt++;
        @(negedge clk_i);
      end
      chk($sformatf("R%0d vector %0d", VECS[v].req, v), got, VECS[v].exp);
      chk($sformatf("R11 write strobes vector %0d", v), wr_cnt, 1);
      if (v == NV - 2) chk("R11 read strobe", rd_cnt, 1);
    end

    // R12 halted holds address, no strobes, cleared by reset
    chk("R12 halted", halted_o, 1);
    hold = rom_addr_o;
    repeat (3) @(negedge clk_i);
    chk("R12 addr frozen", rom_addr_o, hold);
    chk("R12 no strobe", {port_rd_o, port_wr_o}, 0);
    rst_ni = 1'b0;
    #1;
    chk("R12 reset clears halt", halted_o, 0);

    // R13 sequential fetch wraps
    fill(8'hF4);
    restart();
    repeat (258) @(negedge clk_i);
    chk("R13 wrap", rom_addr_o, 8'h02);

    // R4 forward offset zero repeats
    rst_ni = 1'b0;
    rom[1] = 8'h90;
    restart();
    repeat (6) @(negedge clk_i);
    chk("R4 self loop", rom_addr_o, 8'h01);
    chk("R4 not halted", halted_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule